// File: doc/BRIEF.md
# Dual-Link Receiver Output Mode Controller

This block sits behind the link decoder of a pixel receiver. The receiver can run on its own or as one half of a pair that shares a wide display stream. The block decodes two strap inputs into an operating mode. It then forms the even and odd pixel output buses and decides which of them this receiver drives. It also chooses between one and two pixels per clock.

In a pair, the master's single/dual select input is wired to the slave's sync-detect output. While the second link is idle, the master works as a standalone receiver at two pixels per clock and supplies both buses. Once the slave detects valid sync, the master switches to dual-link operation. It then drives only the even bus and releases its odd bus, so that the slave's even bus can carry the odd pixels.

The slave takes the master's data-enable as its line-start reference and begins each line only after it has seen that reference rise. The select input is synchronised and acted on only between lines. Pads, decoding and clock recovery are outside the block; it produces data plus an output-enable for each bus. The strap `role_i` is static. `sync_de_i` and `de_i` are in the local pixel clock domain.

Top module: `dual_link_rx_mode`

## Requirements
- R1: After reset, `even_oe_o`, `odd_oe_o` and `de_o` are 0 and both buses are zero. Both enables stay 0 through the first three rising clock edges after reset release, while the mode is still unresolved.
- R2: With `link_sel_i`=0 and `role_i`=0 (standalone, one pixel per clock), `even_oe_o`=1 and `odd_oe_o`=0. Each pixel appears on `even_o`, with `de_o` following `de_i`, one clock after it is sampled.
- R3: With `link_sel_i`=0 and `role_i`=1 (standalone, two pixels per clock), both enables are 1. Pixels pair up within a line: the first of a pair goes on `even_o` and the second on `odd_o`. `de_o` pulses for one clock after the second pixel is sampled and is 0 on the clock between pulses.
- R4: In two-pixel mode, if a line ends with an unpaired pixel, that pixel is emitted on `even_o` with `odd_o`=0 and `de_o`=1 on the clock after `de_i` is first sampled low.
- R5: With `link_sel_i`=1 and `role_i`=1 (master, dual link), `even_oe_o`=1 and `odd_oe_o`=0. Pixels pass one per clock on `even_o` with one clock of latency.
- R6: With `link_sel_i`=1 and `role_i`=0 (slave), `odd_oe_o` is always 0 and `even_oe_o` follows `sdet_i` one clock later.
- R7: A slave keeps `de_o`=0 and `even_o` zero until a rising edge of `sync_de_i` has been seen after reset. A line starts at the first rise of `de_i` that falls in the same cycle as that edge or after it.
- R8: A slave line, once started, keeps passing pixels until `de_i` falls. A later line whose `de_i` rise was not preceded by a fresh `sync_de_i` rising edge is suppressed.
- R9: A change on `link_sel_i` passes a two-flop synchroniser and updates the mode only at a falling edge of `de_i`. The enables of the new mode appear one clock after the edge where `de_i` is first sampled low, and they never change during an active line or during blanking that follows no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| link_sel_i | input | 1 | Single (0) / dual (1) select; in a master, wired to the slave's sync-detect |
| role_i | input | 1 | Static strap: pixels per clock (0 = one, 1 = two) when single; master (1) / slave (0) when dual |
| sdet_i | input | 1 | Local sync-detect, high when valid sync is arriving |
| sync_de_i | input | 1 | Partner's data-enable, used as the slave's line reference |
| de_i | input | 1 | Local data-enable, high during active video |
| pix_i | input | PIX_W | Local decoded pixel |
| even_o | output | PIX_W | Even pixel bus data |
| even_oe_o | output | 1 | Drive enable for the even bus (0 = high impedance) |
| odd_o | output | PIX_W | Odd pixel bus data |
| odd_oe_o | output | 1 | Drive enable for the odd bus (0 = high impedance) |
| de_o | output | 1 | Output data-enable, aligned with the output buses |

## Verification
Pixel results are due one clock after the input is sampled. In two-pixel mode they are due one clock after the second pixel of a pair, or after the first low `de_i` for a leftover. Enable changes land one clock after the mode register changes. The first mode resolves on the third edge after reset and its enables show on the fourth. A `link_sel_i` change takes effect one clock after the first low `de_i` of the line end. The bench drives inputs just after a rising edge and checks one nanosecond after the following edge. Each check therefore reads the result of exactly one sampled cycle, and checks on mode changes are placed on the exact edge before and after the expected switch.

// File: rtl/dlrx_pkg.sv
package dlrx_pkg;

  typedef enum logic [2:0] {
    MODE_OFF,
    MODE_SGL_1P,
    MODE_SGL_2P,
    MODE_MST_DUAL,
    MODE_SLV
  } dl_mode_e;

  typedef struct packed {
    logic even;
    logic odd;
  } oe_t;

  function automatic dl_mode_e decode_mode(input logic dual, input logic role);
    case ({dual, role})
      2'b00:   return MODE_SGL_1P;
      2'b01:   return MODE_SGL_2P;
      2'b10:   return MODE_SLV;
      default: return MODE_MST_DUAL;
    endcase
  endfunction

  function automatic oe_t mode_oe(input dl_mode_e m, input logic sdet);
    oe_t r;
    r = '0;
    case (m)
      MODE_SGL_1P:   r.even = 1'b1;
      MODE_SGL_2P:   begin r.even = 1'b1; r.odd = 1'b1; end
      MODE_MST_DUAL: r.even = 1'b1;
      MODE_SLV:      r.even = sdet;
      default:       r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dlrx_sync.sv
module dlrx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];

endmodule

// File: rtl/dlrx_mode_ctrl.sv
module dlrx_mode_ctrl
  import dlrx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     link_sel_i,
  input  logic     role_i,
  input  logic     sdet_i,
  input  logic     de_i,
  output dl_mode_e mode_o,
  output logic     even_oe_o,
  output logic     odd_oe_o
);

  localparam int CNT_W = $clog2(SYNC_STAGES + 1);

  logic             sel_s;
  logic [CNT_W-1:0] settle_q;
  logic             ready;
  logic             de_q;
  logic             de_fall;
  logic             commit;
  dl_mode_e         mode_q;
  oe_t              oe_q;
  oe_t              oe_d;

  dlrx_sync #(.STAGES(SYNC_STAGES)) u_sel_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (link_sel_i),
    .q_o    (sel_s)
  );

  assign ready   = (settle_q == CNT_W'(SYNC_STAGES));
  assign de_fall = de_q & ~de_i;
  // first resolution in blanking, later changes only at a line end
  assign commit  = ready & (((mode_q == MODE_OFF) & ~de_i) | de_fall);
  assign oe_d    = mode_oe(mode_q, sdet_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      settle_q <= '0;
      de_q     <= 1'b0;
      mode_q   <= MODE_OFF;
      oe_q     <= '0;
    end else begin
      if (!ready) settle_q <= settle_q + CNT_W'(1);
      de_q <= de_i;
      if (commit) mode_q <= decode_mode(sel_s, role_i);
      oe_q <= oe_d;
    end
  end

  assign mode_o    = mode_q;
  assign even_oe_o = oe_q.even;
  assign odd_oe_o  = oe_q.odd;

endmodule

// File: rtl/dlrx_slave_align.sv
module dlrx_slave_align (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_de_i,
  input  logic de_i,
  output logic gate_o
);

  logic sync_q;
  logic de_q;
  logic pend_q;
  logic line_q;
  logic sync_rise;
  logic de_rise;
  logic start;

  assign sync_rise = sync_de_i & ~sync_q;
  assign de_rise   = de_i & ~de_q;
  assign start     = de_rise & (pend_q | sync_rise);
  assign gate_o    = de_i & (line_q | start);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 1'b0;
      de_q   <= 1'b0;
      pend_q <= 1'b0;
      line_q <= 1'b0;
    end else begin
      sync_q <= sync_de_i;
      de_q   <= de_i;
      if (start)          pend_q <= 1'b0;
      else if (sync_rise) pend_q <= 1'b1;
      if (!de_i)      line_q <= 1'b0;
      else if (start) line_q <= 1'b1;
    end
  end

endmodule

// File: rtl/dlrx_pix_path.sv
module dlrx_pix_path
  import dlrx_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  dl_mode_e         mode_i,
  input  logic             de_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             slv_gate_i,
  output logic [PIX_W-1:0] even_o,
  output logic [PIX_W-1:0] odd_o,
  output logic             de_o
);

  logic [PIX_W-1:0] even_q;
  logic [PIX_W-1:0] odd_q;
  logic [PIX_W-1:0] hold_q;
  logic             phase_q;
  logic             de_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      even_q  <= '0;
      odd_q   <= '0;
      hold_q  <= '0;
      phase_q <= 1'b0;
      de_q    <= 1'b0;
    end else begin
      case (mode_i)
        MODE_SGL_1P, MODE_MST_DUAL: begin
          even_q  <= de_i ? pix_i : '0;
          odd_q   <= '0;
          de_q    <= de_i;
          phase_q <= 1'b0;
        end
        MODE_SGL_2P: begin
          if (de_i && !phase_q) begin
            hold_q  <= pix_i;
            phase_q <= 1'b1;
            de_q    <= 1'b0;
          end else if (de_i) begin
            even_q  <= hold_q;
            odd_q   <= pix_i;
            phase_q <= 1'b0;
            de_q    <= 1'b1;
          end else if (phase_q) begin
            // unpaired pixel at line end
            even_q  <= hold_q;
            odd_q   <= '0;
            phase_q <= 1'b0;
            de_q    <= 1'b1;
          end else begin
            de_q    <= 1'b0;
          end
        end
        MODE_SLV: begin
          even_q  <= slv_gate_i ? pix_i : '0;
          odd_q   <= '0;
          de_q    <= slv_gate_i;
          phase_q <= 1'b0;
        end
        default: begin
          even_q  <= '0;
          odd_q   <= '0;
          de_q    <= 1'b0;
          phase_q <= 1'b0;
        end
      endcase
    end
  end

  assign even_o = even_q;
  assign odd_o  = odd_q;
  assign de_o   = de_q;

endmodule

// File: rtl/dual_link_rx_mode.sv
module dual_link_rx_mode
  import dlrx_pkg::*;
#(
  parameter int PIX_W       = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             link_sel_i,
  input  logic             role_i,
  input  logic             sdet_i,
  input  logic             sync_de_i,
  input  logic             de_i,
  input  logic [PIX_W-1:0] pix_i,
  output logic [PIX_W-1:0] even_o,
  output logic             even_oe_o,
  output logic [PIX_W-1:0] odd_o,
  output logic             odd_oe_o,
  output logic             de_o
);

  dl_mode_e mode;
  logic     slv_gate;

  dlrx_mode_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .link_sel_i (link_sel_i),
    .role_i     (role_i),
    .sdet_i     (sdet_i),
    .de_i       (de_i),
    .mode_o     (mode),
    .even_oe_o  (even_oe_o),
    .odd_oe_o   (odd_oe_o)
  );

  dlrx_slave_align u_align (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sync_de_i (sync_de_i),
    .de_i      (de_i),
    .gate_o    (slv_gate)
  );

  dlrx_pix_path #(.PIX_W(PIX_W)) u_pix (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode),
    .de_i       (de_i),
    .pix_i      (pix_i),
    .slv_gate_i (slv_gate),
    .even_o     (even_o),
    .odd_o      (odd_o),
    .de_o       (de_o)
  );

endmodule

// File: rtl/dlrx_mode_chk.sv
module dlrx_mode_chk
  import dlrx_pkg::*;
(
  input logic     clk_i,
  input logic     rst_ni,
  input logic     de_i,
  input dl_mode_e mode_i,
  input logic     even_oe_i,
  input logic     odd_oe_i,
  input logic     de_o_i
);

  p_oe_off_unresolved_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_OFF) |=> (!even_oe_i && !odd_oe_i));

  p_both_oe_pair_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_SGL_2P) |=> (even_oe_i && odd_oe_i));

  p_pair_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_SGL_2P && de_o_i) |=> !de_o_i);

  p_odd_hiz_master_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_MST_DUAL) |=> (even_oe_i && !odd_oe_i));

  p_odd_hiz_slave_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_SLV) |=> !odd_oe_i);

  p_slave_de_in_line_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_SLV && de_o_i) |-> $past(de_i));

  p_mode_at_blank_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != $past(mode_i)) |-> !$past(de_i));

endmodule

bind dual_link_rx_mode dlrx_mode_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .de_i      (de_i),
  .mode_i    (mode),
  .even_oe_i (even_oe_o),
  .odd_oe_i  (odd_oe_o),
  .de_o_i    (de_o)
);

// File: tb/dual_link_rx_mode_tb.sv
module dual_link_rx_mode_tb;

  localparam int PW = 24;
  localparam int NV = 10;

  typedef struct packed {
    logic          de;
    logic [PW-1:0] pix;
    logic          xde;
    logic [PW-1:0] xev;
    logic [PW-1:0] xod;
  } vec_t;

  // two-pixel mode: line of 5 (leftover), blank, line of 2
  localparam vec_t VEC [NV] = '{
    '{1'b1, 24'hA00001, 1'b0, 24'h0,      24'h0},
    '{1'b1, 24'hA00002, 1'b1, 24'hA00001, 24'hA00002},
    '{1'b1, 24'hA00003, 1'b0, 24'h0,      24'h0},
    '{1'b1, 24'hA00004, 1'b1, 24'hA00003, 24'hA00004},
    '{1'b1, 24'hA00005, 1'b0, 24'h0,      24'h0},
    '{1'b0, 24'h0,      1'b1, 24'hA00005, 24'h0},
    '{1'b0, 24'h0,      1'b0, 24'h0,      24'h0},
    '{1'b1, 24'hB00001, 1'b0, 24'h0,      24'h0},
    '{1'b1, 24'hB00002, 1'b1, 24'hB00001, 24'hB00002},
    '{1'b0, 24'h0,      1'b0, 24'h0,      24'h0}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          link_sel_i = 1'b0;
  logic          role_i = 1'b0;
  logic          sdet_i = 1'b0;
  logic          sync_de_i = 1'b0;
  logic          de_i = 1'b0;
  logic [PW-1:0] pix_i = '0;
  logic [PW-1:0] even_o;
  logic          even_oe_o;
  logic [PW-1:0] odd_o;
  logic          odd_oe_o;
  logic          de_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  dual_link_rx_mode #(.PIX_W(PW)) u_dut (
    .clk_i, .rst_ni, .link_sel_i, .role_i, .sdet_i, .sync_de_i,
    .de_i, .pix_i, .even_o, .even_oe_o, .odd_o, .odd_oe_o, .de_o
  );

  task automatic chk(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic de, input logic [PW-1:0] p);
    de_i  = de;
    pix_i = p;
    @(posedge clk_i);
    #1;
  endtask

  task automatic do_reset(input logic ls, input logic role, input logic sd);
    @(negedge clk_i);
    rst_ni     = 1'b0;
    link_sel_i = ls;
    role_i     = role;
    sdet_i     = sd;
    sync_de_i  = 1'b0;
    de_i       = 1'b0;
    pix_i      = '0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state, then unresolved window
    @(negedge clk_i);
    #1;
    chk("R1 even_oe in reset", {23'b0, even_oe_o}, 0);
    chk("R1 odd_oe in reset",  {23'b0, odd_oe_o}, 0);
    chk("R1 de_o in reset",    {23'b0, de_o}, 0);
    chk("R1 even in reset",    even_o, 0);
    do_reset(1'b0, 1'b1, 1'b0);
    for (int k = 0; k < 3; k++) begin
      step(1'b0, '0);
      chk("R1 oe off while unresolved", {22'b0, even_oe_o, odd_oe_o}, 0);
    end
    step(1'b0, '0);
    chk("R3 both oe after resolve", {22'b0, even_oe_o, odd_oe_o}, 3);

    // R3/R4: vector table
    for (int i = 0; i < NV; i++) begin
      step(VEC[i].de, VEC[i].pix);
      chk($sformatf("R3 de_o vec%0d", i), {23'b0, de_o}, {23'b0, VEC[i].xde});
      if (VEC[i].xde) begin
        chk($sformatf("R3 R4 even vec%0d", i), even_o, VEC[i].xev);
        chk($sformatf("R3 R4 odd vec%0d", i),  odd_o,  VEC[i].xod);
      end
    end

    // R9: switch to master dual at line end
    link_sel_i = 1'b1;
    step(1'b1, 24'hC1);
    step(1'b1, 24'hC2);
    step(1'b1, 24'hC3);
    step(1'b1, 24'hC4);
    chk("R9 odd_oe held during line", {23'b0, odd_oe_o}, 1);
    step(1'b0, '0);
    chk("R9 odd_oe on switch edge", {23'b0, odd_oe_o}, 1);
    step(1'b0, '0);
    chk("R9 R5 odd_oe released", {23'b0, odd_oe_o}, 0);
    chk("R5 even_oe master", {23'b0, even_oe_o}, 1);
    step(1'b1, 24'hC5);
    chk("R5 de_o", {23'b0, de_o}, 1);
    chk("R5 even pixel", even_o, 24'hC5);
    chk("R5 odd zero", odd_o, 0);
    step(1'b0, '0);
    chk("R5 de_o low", {23'b0, de_o}, 0);

    // R9: no change in blanking without a line end
    link_sel_i = 1'b0;
    repeat (4) step(1'b0, '0);
    chk("R9 no switch in blanking", {23'b0, odd_oe_o}, 0);
    step(1'b1, 24'hD1);
    step(1'b0, '0);
    step(1'b0, '0);
    chk("R9 back to two-pixel", {23'b0, odd_oe_o}, 1);

    // R2: standalone one pixel per clock
    do_reset(1'b0, 1'b0, 1'b0);
    repeat (5) step(1'b0, '0);
    chk("R2 oe pattern", {22'b0, even_oe_o, odd_oe_o}, 2);
    step(1'b1, 24'hE1);
    chk("R2 de_o", {23'b0, de_o}, 1);
    chk("R2 even pixel", even_o, 24'hE1);
    step(1'b0, '0);
    chk("R2 de_o low", {23'b0, de_o}, 0);

    // R6/R7/R8: slave
    do_reset(1'b1, 1'b0, 1'b0);
    repeat (5) step(1'b0, '0);
    chk("R6 slave idle hiz", {22'b0, even_oe_o, odd_oe_o}, 0);
    sdet_i = 1'b1;
    step(1'b0, '0);
    chk("R6 slave drives even", {22'b0, even_oe_o, odd_oe_o}, 2);
    step(1'b1, 24'hF1);
    chk("R7 held before sync", {23'b0, de_o}, 0);
    chk("R7 even zero before sync", even_o, 0);
    step(1'b0, '0);
    sync_de_i = 1'b1;
    step(1'b0, '0);
    step(1'b1, 24'h61);
    chk("R7 line starts", {23'b0, de_o}, 1);
    chk("R7 first pixel", even_o, 24'h61);
    step(1'b1, 24'h62);
    chk("R8 line continues", even_o, 24'h62);
    step(1'b0, '0);
    chk("R8 line ends", {23'b0, de_o}, 0);
    step(1'b1, 24'h71);
    chk("R8 no fresh sync suppressed", {23'b0, de_o}, 0);
    step(1'b0, '0);
    sync_de_i = 1'b0;
    step(1'b0, '0);
    sync_de_i = 1'b1;
    step(1'b1, 24'h72);
    chk("R7 same-cycle sync start", {23'b0, de_o}, 1);
    chk("R7 same-cycle pixel", even_o, 24'h72);
    step(1'b0, '0);
    sdet_i = 1'b0;
    step(1'b0, '0);
    chk("R6 slave link lost hiz", {23'b0, even_oe_o}, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule